// File: doc/BRIEF.md
# Resequencing Multi-Queue Cell Transmitter

This block serves one output line of a switch built from several identical switch elements working in parallel. Each element holds its own queue of cells bound for this line. The block pulls cells from the heads of those queues, one per slot, so that the line carries them in the order in which they entered the switch. Queue storage sits outside the block. The block sees only each queue's head entry, which holds a valid flag, a cell-cycle tag and the cell word. It answers with one dequeue strobe per queue and a registered cell on the serial side.

Cells arrive at the elements on a fixed schedule. One slot after reset, slot 0 delivers element 0's group for cycle 0. Each later slot delivers the group of the next element. After the last element the schedule wraps to element 0 of the next cycle. An internal arrival clock tracks that schedule. A drain pointer (cycle, element) names the group now being emitted. A group is finished when its arrival slot has passed and the head of its queue no longer carries its cycle tag. The pointer then steps to the following group. When that group's arrival slot has also passed and it holds a cell, that cell leaves in the same slot.

The drain sequencer has three states. ST_OPEN is the first slot after reset, while group (0,0) is still arriving. ST_DRAIN emits from the current group, or steps past it. ST_SEEK holds for one slot when the current group is finished but the following group is still arriving. The transitions are:
- ST_OPEN→ST_DRAIN always.
- ST_DRAIN→ST_DRAIN when a cell is sent from the current group, or when the pointer steps to a closed next group.
- ST_DRAIN→ST_SEEK when the current group is finished and the next group is open.
- ST_SEEK→ST_DRAIN always, with a step and an optional send.

Top module: `rsq_transmitter`

## Requirements
- R1: While reset is high, and in the first slot after it, out_valid is 0 and every dequeue strobe is 0.
- R2: At most one bit of deq is set in any slot.
- R3: Slot s after reset is the arrival slot of element s mod NUM_ELEM in cycle s div NUM_ELEM. Groups are emitted in arrival-slot order: every cell of group (k,e) goes out before any cell of group (k,e+1), and group (k+1,0) follows group (k,NUM_ELEM-1).
- R4: Element e's head tag is head_tag[e*TAG_W +: TAG_W], its cell is head_cell[e*CELL_W +: CELL_W], and its strobe is deq[e]. A head whose tag is not the cycle of the group being drained stays queued until the drain reaches its own group, even while earlier groups are unfinished.
- R5: A group with no cells produces no output and costs the drain at most one slot.
- R6: A group is never finished or drained during its own arrival slot. When the drain has caught up, a cell written in arrival slot s is on the output in slot s+2.
- R7: Cells of one group leave in the order they were queued.
- R8: A head dequeued in slot t appears on out_cell with out_valid high in slot t+1, and out_valid is high only in such slots.
- R9: When the current group finishes and the next group is closed and holds a cell, that cell is dequeued in the same slot, so full back-to-back groups leave with no idle slot.
- R10: In a slot with no eligible head, no strobe is raised, and out_valid is low in the slot after it.
- R11: Tags are compared modulo 2^TAG_W, so ordering holds across wrap-around of the cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| head_valid | input | NUM_ELEM | Queue e holds at least one cell |
| head_tag | input | NUM_ELEM*TAG_W | Cycle tag of each queue head |
| head_cell | input | NUM_ELEM*CELL_W | Cell word at each queue head |
| deq | output | NUM_ELEM | Pop strobe for each queue, at most one set |
| out_valid | output | 1 | A cell is on out_cell this slot |
| out_cell | output | CELL_W | Cell sent on the output line |

## Verification
Two events can fall in the same slot. One is closing a finished group and sending the first cell of the next group. The other is a new group landing in a queue whose older group is still being drained. The first is provoked with several full groups back to back, and judged by the output staying busy with no gap and in strict group order. The second is provoked by giving element 0 a group in two consecutive cycles while a long group at element 1 holds the drain back. It is judged by the later-cycle cells leaving only after the long group, and by sparse single cells leaving exactly two slots after they arrive.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    // Drain sequencer states
    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_SEEK  = 2'd2
    } drain_state_e;

    // Which group supplies the cell sent this slot
    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_CUR  = 2'd1,
        PICK_NXT  = 2'd2
    } pick_e;

endpackage

// File: rtl/rsq_arrival_clock.sv
module rsq_arrival_clock #(
    parameter int NUM_ELEM = 4,
    parameter int TAG_W    = 4,
    parameter int ELEM_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    output logic [TAG_W-1:0]  arr_cyc,
    output logic [ELEM_W-1:0] arr_elem
);

    localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(NUM_ELEM - 1);

    // Position of the group that is landing in its queue during this slot
    always_ff @(posedge clk) begin
        if (rst) begin
            arr_cyc  <= '0;
            arr_elem <= '0;
        end else if (arr_elem == LAST_ELEM) begin
            arr_elem <= '0;
            arr_cyc  <= arr_cyc + 1'b1;
        end else begin
            arr_elem <= arr_elem + 1'b1;
        end
    end

endmodule

// File: rtl/rsq_group_probe.sv
module rsq_group_probe #(
    parameter int NUM_ELEM = 4,
    parameter int TAG_W    = 4,
    parameter int CELL_W   = 16,
    parameter int ELEM_W   = 2
) (
    input  logic [ELEM_W-1:0]          grp_elem,
    input  logic [TAG_W-1:0]           grp_cyc,
    input  logic [NUM_ELEM-1:0]        head_valid,
    input  logic [NUM_ELEM*TAG_W-1:0]  head_tag,
    input  logic [NUM_ELEM*CELL_W-1:0] head_cell,
    output logic                       grp_ready,
    output logic [CELL_W-1:0]          grp_cell
);

    logic [TAG_W-1:0]    tag_a  [NUM_ELEM];
    logic [CELL_W-1:0]   cell_a [NUM_ELEM];
    logic [NUM_ELEM-1:0] hit;

    // A head belongs to the probed group when it sits in that element's
    // queue and carries that group's cycle tag
    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_lane
        assign tag_a[g]  = head_tag[g*TAG_W +: TAG_W];
        assign cell_a[g] = head_cell[g*CELL_W +: CELL_W];
        assign hit[g]    = head_valid[g] && (tag_a[g] == grp_cyc)
                           && (grp_elem == ELEM_W'(g));
    end

    always_comb begin
        grp_ready = |hit;
        grp_cell  = '0;
        for (int e = 0; e < NUM_ELEM; e++) begin
            if (hit[e]) grp_cell = cell_a[e];
        end
    end

endmodule

// File: rtl/rsq_drain_fsm.sv
module rsq_drain_fsm
    import rsq_pkg::*;
#(
    parameter int NUM_ELEM = 4,
    parameter int TAG_W    = 4,
    parameter int ELEM_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TAG_W-1:0]  arr_cyc,
    input  logic [ELEM_W-1:0] arr_elem,
    input  logic              cur_ready,
    input  logic              nxt_ready,
    output logic [TAG_W-1:0]  cur_cyc,
    output logic [ELEM_W-1:0] cur_elem,
    output logic [TAG_W-1:0]  nxt_cyc,
    output logic [ELEM_W-1:0] nxt_elem,
    output pick_e             pick
);

    localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(NUM_ELEM - 1);

    drain_state_e state, state_d;
    logic         step;
    logic         nxt_open;

    // Group that follows the current one in arrival-slot order
    always_comb begin
        if (cur_elem == LAST_ELEM) begin
            nxt_elem = '0;
            nxt_cyc  = cur_cyc + 1'b1;
        end else begin
            nxt_elem = cur_elem + 1'b1;
            nxt_cyc  = cur_cyc;
        end
    end

    // The following group is open while its cells are being written
    assign nxt_open = (nxt_cyc == arr_cyc) && (nxt_elem == arr_elem);

    // Next state and pointer step
    always_comb begin
        state_d = state;
        step    = 1'b0;
        unique case (state)
            ST_OPEN: begin
                state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!cur_ready) begin
                    if (!nxt_open) step = 1'b1;
                    else           state_d = ST_SEEK;
                end
            end
            ST_SEEK: begin
                step    = 1'b1;
                state_d = ST_DRAIN;
            end
            default: begin
                state_d = ST_OPEN;
            end
        endcase
    end

    // State register and drain pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_OPEN;
            cur_cyc  <= '0;
            cur_elem <= '0;
        end else begin
            state <= state_d;
            if (step) begin
                cur_cyc  <= nxt_cyc;
                cur_elem <= nxt_elem;
            end
        end
    end

    // Output decision: which group, if any, gives up its head this slot
    always_comb begin
        pick = PICK_NONE;
        unique case (state)
            ST_DRAIN: begin
                if (cur_ready)                   pick = PICK_CUR;
                else if (!nxt_open && nxt_ready) pick = PICK_NXT;
            end
            ST_SEEK: begin
                if (nxt_ready) pick = PICK_NXT;
            end
            default: begin
                pick = PICK_NONE;
            end
        endcase
    end

endmodule

// File: rtl/rsq_transmitter.sv
module rsq_transmitter
    import rsq_pkg::*;
#(
    parameter int NUM_ELEM = 4,
    parameter int TAG_W    = 4,
    parameter int CELL_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_ELEM-1:0]        head_valid,
    input  logic [NUM_ELEM*TAG_W-1:0]  head_tag,
    input  logic [NUM_ELEM*CELL_W-1:0] head_cell,
    output logic [NUM_ELEM-1:0]        deq,
    output logic                       out_valid,
    output logic [CELL_W-1:0]          out_cell
);

    localparam int ELEM_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1;

    logic [TAG_W-1:0]  arr_cyc,  cur_cyc,  nxt_cyc;
    logic [ELEM_W-1:0] arr_elem, cur_elem, nxt_elem;
    logic              cur_ready, nxt_ready;
    logic [CELL_W-1:0] cur_cell, nxt_cell, sel_cell;
    pick_e             pick;
    logic              take;

    rsq_arrival_clock #(
        .NUM_ELEM(NUM_ELEM), .TAG_W(TAG_W), .ELEM_W(ELEM_W)
    ) u_arrival (
        .clk(clk), .rst(rst), .arr_cyc(arr_cyc), .arr_elem(arr_elem)
    );

    rsq_group_probe #(
        .NUM_ELEM(NUM_ELEM), .TAG_W(TAG_W), .CELL_W(CELL_W), .ELEM_W(ELEM_W)
    ) u_probe_cur (
        .grp_elem(cur_elem), .grp_cyc(cur_cyc),
        .head_valid(head_valid), .head_tag(head_tag), .head_cell(head_cell),
        .grp_ready(cur_ready), .grp_cell(cur_cell)
    );

    rsq_group_probe #(
        .NUM_ELEM(NUM_ELEM), .TAG_W(TAG_W), .CELL_W(CELL_W), .ELEM_W(ELEM_W)
    ) u_probe_nxt (
        .grp_elem(nxt_elem), .grp_cyc(nxt_cyc),
        .head_valid(head_valid), .head_tag(head_tag), .head_cell(head_cell),
        .grp_ready(nxt_ready), .grp_cell(nxt_cell)
    );

    rsq_drain_fsm #(
        .NUM_ELEM(NUM_ELEM), .TAG_W(TAG_W), .ELEM_W(ELEM_W)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .arr_cyc(arr_cyc), .arr_elem(arr_elem),
        .cur_ready(cur_ready), .nxt_ready(nxt_ready),
        .cur_cyc(cur_cyc), .cur_elem(cur_elem),
        .nxt_cyc(nxt_cyc), .nxt_elem(nxt_elem),
        .pick(pick)
    );

    assign take     = (pick != PICK_NONE);
    assign sel_cell = (pick == PICK_NXT) ? nxt_cell : cur_cell;

    // One pop strobe per queue, raised for the element that was picked
    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_deq
        assign deq[g] = ((pick == PICK_CUR) && (cur_elem == ELEM_W'(g)))
                     || ((pick == PICK_NXT) && (nxt_elem == ELEM_W'(g)));
    end

    // Serial-side register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_cell  <= '0;
        end else begin
            out_valid <= take;
            if (take) out_cell <= sel_cell;
        end
    end

endmodule

// File: rtl/rsq_transmitter_chk.sv
module rsq_transmitter_chk #(
    parameter int NUM_ELEM = 4,
    parameter int TAG_W    = 4,
    parameter int ELEM_W   = 2
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_ELEM-1:0] deq,
    input logic [NUM_ELEM-1:0] head_valid,
    input logic                out_valid,
    input logic [TAG_W-1:0]    cur_cyc,
    input logic [ELEM_W-1:0]   cur_elem,
    input logic [TAG_W-1:0]    arr_cyc,
    input logic [ELEM_W-1:0]   arr_elem
);

    localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(NUM_ELEM - 1);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && (deq == '0)));

    // R2
    single_pop_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(deq));

    // R8
    out_follows_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (|deq) |=> out_valid);

    // R8
    no_spurious_out_chk: assert property (@(posedge clk) disable iff (rst)
        !(|deq) |=> !out_valid);

    // R10
    idle_no_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (head_valid == '0) |-> (deq == '0));

    // R4
    pop_needs_head_chk: assert property (@(posedge clk) disable iff (rst)
        ((deq & ~head_valid) == '0));

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_elem != $past(cur_elem)) |->
        (($past(cur_elem) == LAST_ELEM) ? (cur_elem == '0)
                                        : (cur_elem == $past(cur_elem) + 1'b1)));

    // R11
    cyc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_cyc != $past(cur_cyc)) |->
        ((cur_elem == '0) && (cur_cyc == $past(cur_cyc) + 1'b1)));

    // R6
    open_group_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((cur_cyc == arr_cyc) && (cur_elem == arr_elem)) |-> (deq == '0));

endmodule

bind rsq_transmitter rsq_transmitter_chk #(
    .NUM_ELEM(NUM_ELEM), .TAG_W(TAG_W), .ELEM_W(ELEM_W)
) u_chk (
    .clk(clk), .rst(rst), .deq(deq), .head_valid(head_valid),
    .out_valid(out_valid), .cur_cyc(cur_cyc), .cur_elem(cur_elem),
    .arr_cyc(arr_cyc), .arr_elem(arr_elem)
);

// File: tb/tb_rsq_transmitter.sv
`timescale 1ns/1ps
module tb_rsq_transmitter;

    localparam int S      = 4;
    localparam int TAG_W  = 4;
    localparam int CELL_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic [S-1:0]        head_valid;
    logic [S*TAG_W-1:0]  head_tag;
    logic [S*CELL_W-1:0] head_cell;
    logic [S-1:0]        deq;
    logic                out_valid;
    logic [CELL_W-1:0]   out_cell;

    rsq_transmitter #(.NUM_ELEM(S), .TAG_W(TAG_W), .CELL_W(CELL_W)) dut (
        .clk(clk), .rst(rst), .head_valid(head_valid), .head_tag(head_tag),
        .head_cell(head_cell), .deq(deq), .out_valid(out_valid), .out_cell(out_cell)
    );

    // Arrival plan: number of cells landing in each slot
    int plan [256];
    int slot_ctr;

    function automatic logic [CELL_W-1:0] cell_of(int s, int j);
        logic [7:0] hi = s[7:0];
        logic [7:0] lo = j[7:0];
        return {hi, lo};
    endfunction

    // Queue model for the switch elements
    logic [CELL_W-1:0] qc [S][64];
    logic [TAG_W-1:0]  qt [S][64];
    logic [5:0]        wp [S];
    logic [5:0]        rp [S];

    always @(posedge clk) begin
        if (rst) begin
            slot_ctr <= 0;
            for (int e = 0; e < S; e++) begin
                wp[e] <= '0;
                rp[e] <= '0;
            end
        end else begin
            slot_ctr <= slot_ctr + 1;
            for (int e = 0; e < S; e++) begin
                if (deq[e]) rp[e] <= rp[e] + 6'd1;
            end
            if (slot_ctr < 256 && plan[slot_ctr] > 0) begin
                for (int j = 0; j < plan[slot_ctr]; j++) begin
                    qc[slot_ctr % S][wp[slot_ctr % S] + 6'(j)] <= cell_of(slot_ctr, j);
                    qt[slot_ctr % S][wp[slot_ctr % S] + 6'(j)] <= TAG_W'(slot_ctr / S);
                end
                wp[slot_ctr % S] <= wp[slot_ctr % S] + 6'(plan[slot_ctr]);
            end
        end
    end

    always_comb begin
        for (int e = 0; e < S; e++) begin
            head_valid[e]                  = (wp[e] != rp[e]);
            head_tag[e*TAG_W +: TAG_W]     = qt[e][rp[e]];
            head_cell[e*CELL_W +: CELL_W]  = qc[e][rp[e]];
        end
    end

    // Output monitor
    int                nrec;
    logic [CELL_W-1:0] rec [512];
    int                rec_slot [512];
    int                err_onehot, err_follow, err_idle;
    logic              pend;
    logic [CELL_W-1:0] pend_cell;

    always @(negedge clk) begin
        if (rst) begin
            nrec = 0; err_onehot = 0; err_follow = 0; err_idle = 0;
            pend = 1'b0; pend_cell = '0;
        end else begin
            if (out_valid !== pend) err_follow++;
            else if (out_valid && (out_cell !== pend_cell)) err_follow++;
            if (out_valid && nrec < 512) begin
                rec[nrec] = out_cell;
                rec_slot[nrec] = slot_ctr;
                nrec++;
            end
            if (!$onehot0(deq)) err_onehot++;
            if (head_valid == '0 && deq != '0) err_idle++;
            pend = |deq;
            pend_cell = '0;
            for (int e = 0; e < S; e++)
                if (deq[e]) pend_cell = head_cell[e*CELL_W +: CELL_W];
        end
    end

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic begin_scn();
        @(posedge clk); #2 rst = 1'b1;
        for (int s = 0; s < 256; s++) plan[s] = 0;
        repeat (3) @(posedge clk);
    endtask

    task automatic go();
        @(posedge clk); #2 rst = 1'b0;
    endtask

    // Expected stream: groups in arrival-slot order, cells in queue order
    task automatic compare_order(string req, string what);
        int nexp = 0;
        int mism = 0;
        for (int s = 0; s < 256; s++) begin
            for (int j = 0; j < plan[s]; j++) begin
                if (nexp >= nrec || rec[nexp] !== cell_of(s, j)) mism++;
                nexp++;
            end
        end
        chk(nrec == nexp, req, {what, " cell count"}, nrec, nexp);
        chk(mism == 0, req, {what, " order mismatches"}, mism, 0);
    endtask

    task automatic t_reset();
        begin_scn();
        @(negedge clk);
        chk(!out_valid && deq == '0, "R1", "quiet in reset", int'(out_valid), 0);
        go();
        @(negedge clk);
        chk(!out_valid && deq == '0, "R1", "quiet in first slot", int'(deq), 0);
    endtask

    task automatic t_chain();
        begin_scn();
        for (int s = 0; s < 4; s++) plan[s] = 3;
        go();
        repeat (40) @(negedge clk);
        compare_order("R3 R7", "full groups");
        chk(rec_slot[0] == 2, "R8", "first output slot", rec_slot[0], 2);
        chk(nrec > 0 && rec_slot[nrec-1] - rec_slot[0] == nrec - 1, "R9",
            "gap-free span", nrec > 0 ? rec_slot[nrec-1] - rec_slot[0] : -1, nrec - 1);
        chk(err_follow == 0, "R8", "output follows pop", err_follow, 0);
        chk(err_onehot == 0, "R2", "single pop per slot", err_onehot, 0);
    endtask

    task automatic t_wait();
        begin_scn();
        plan[0] = 1; plan[1] = 6; plan[4] = 2; plan[5] = 1;
        go();
        repeat (40) @(negedge clk);
        compare_order("R4", "later cycle waits");
        chk(err_follow == 0, "R7", "cell contents per pop", err_follow, 0);
    endtask

    task automatic t_sparse();
        begin_scn();
        plan[2] = 1; plan[9] = 1; plan[17] = 1;
        go();
        repeat (60) @(negedge clk);
        compare_order("R5", "empty groups skipped");
        chk(rec_slot[0] == 4,  "R6", "slot 2 cell latency",  rec_slot[0], 4);
        chk(rec_slot[1] == 11, "R6", "slot 9 cell latency",  rec_slot[1], 11);
        chk(rec_slot[2] == 19, "R6", "slot 17 cell latency", rec_slot[2], 19);
        chk(err_idle == 0, "R10", "no pop without head", err_idle, 0);
        chk(!out_valid && deq == '0, "R10", "quiet after drain", int'(out_valid), 0);
    endtask

    task automatic t_wrap();
        begin_scn();
        for (int s = 0; s < 100; s++)
            plan[s] = (s % 4 == 1) ? 2 : ((s % 3 == 0) ? 1 : 0);
        go();
        repeat (200) @(negedge clk);
        compare_order("R11", "tag wrap-around");
        chk(err_follow == 0, "R8", "output follows pop over wrap", err_follow, 0);
        chk(err_onehot == 0, "R2", "single pop over wrap", err_onehot, 0);
    endtask

    initial begin
        for (int s = 0; s < 256; s++) plan[s] = 0;
        t_reset();
        t_chain();
        t_wait();
        t_sparse();
        t_wrap();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule